// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit processor built around one shared bus. A 4-bit step counter and a 4-bit opcode register drive a microcode table. Each table word has sixteen direct control lines for the datapath, plus a 3-bit select field. A small decoder turns that field into the output enable of exactly one ALU function. The datapath registers, the memory and the clock source are outside the block. The block only says, cycle by cycle, which of them drive or capture the bus.

The table address is eleven bits wide. Bits 3:0 hold the step count. Bits 7:4 hold the opcode. Bits 10:8 hold the comparison flags, with less in bit 8, equal in bit 9 and greater in bit 10.

Every instruction starts with the same three fetch steps. Step `ST_FADDR` (0) puts the program counter into the memory address register. Step `ST_FREAD` (1) reads memory into the opcode register. Step `ST_FINC` (2) increments the program counter. From step 3 on, the execute steps depend on the opcode. An instruction ends with a word that asserts both the step clear line and the opcode clear line. That returns the sequencer to `ST_FADDR` with an empty opcode register.

Transitions:
- Normal advance: the step goes to step + 1.
- End of instruction: the step goes to `ST_FADDR` and the opcode to 0.
- Wrap: the step goes from 15 to 0 without the opcode being cleared.
- Reset: both the step and the opcode go to 0.

Top module: `ucode_sequencer`

Control line bits (ctrl_o):

| Bit | Value | Line |
|-----|-------|------|
| 0 | 0x0001 | PC drives bus |
| 1 | 0x0002 | MAR capture |
| 2 | 0x0004 | RAM drives bus |
| 3 | 0x0008 | opcode register capture |
| 4 | 0x0010 | PC increment |
| 5 | 0x0020 | accumulator capture |
| 6 | 0x0040 | accumulator drives bus |
| 7 | 0x0080 | B register capture |
| 8 | 0x0100 | output register capture |
| 9 | 0x0200 | RAM write |
| 10 | 0x0400 | PC load |
| 11 | 0x0800 | opcode clear |
| 12 | 0x1000 | step clear |
| 13 | 0x2000 | halt indicator |
| 14, 15 | — | reserved, always 0 |

Opcodes:

| Value | Instruction |
|-------|-------------|
| 0 | NOP |
| 1 | load A immediate |
| 2 | ADD |
| 3 | SUB |
| 4 | AND |
| 5 | OR |
| 6 | XOR |
| 7 | NOT |
| 8 | load B immediate |
| 9 | OUT |
| 10 | JMP |
| 11 | jump if equal |
| 12 | jump if less |
| 13 | jump if greater |
| 14 | store A |
| 15 | HALT |

## Requirements
- R1: A synchronous reset leaves step_o=0, opcode_o=0, ctrl_o=0x0003 and alu_oe_o=0.
- R2: The fetch steps produce ctrl_o=0x0003 at step 0, then 0x000C at step 1, then 0x0010 at step 2, whatever the opcode and the flags.
- R3: In the cycle where ctrl_o bit 3 is high, opcode_o captures bus_in[3:0] at the clock edge, and bus_in[7:4] has no effect on it.
- R4: The table address is {cmp_flags, opcode, step}, so the same opcode and step give different words under different flags.
- R5: A word with bit 12 set also has bit 11 set, and on the next cycle step_o=0 and opcode_o=0.
- R6: If no clear is asserted, the step advances by one each cycle, and from 15 it wraps to 0 with the opcode kept.
- R7: At step 3, opcodes 2 to 7 give ctrl_o=0x1820 and set only alu_oe_o bit (opcode-2). Select codes 1..6 map to ADD, SUB, AND, OR, XOR, NOT.
- R8: Select codes 0 and 7 enable no ALU output, so alu_oe_o is 0 in every step that is not an ALU step.
- R9: Load A immediate gives 0x0003, 0x0024, 0x1810 at steps 3 to 5. Load B immediate gives 0x0003, 0x0084, 0x1810.
- R10: A jump gives 0x0003 then 0x1C04 when taken, and 0x1810 at step 3 when not taken. JMP is always taken. The conditional jumps test cmp_flags bit 1 (equal), bit 0 (less) and bit 2 (greater).
- R11: OUT gives 0x1940 at step 3. Store A gives 0x0003, 0x0006, 0x1A50 at steps 3 to 5. NOP gives 0x1800 at step 3.
- R12: HALT gives 0x2000 at steps 3 to 15. A reset asserted during any step clears the step and the opcode at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 8 | Shared bus; only the low nibble is used |
| cmp_flags | input | 3 | Comparison flags {greater, equal, less} |
| ctrl_o | output | 16 | Direct control lines from the microcode word |
| alu_oe_o | output | 6 | One-hot ALU output enables (ADD..NOT) |
| step_o | output | 4 | Current step count |
| opcode_o | output | 4 | Held opcode |

## Verification
Every opcode is fetched through the real fetch steps with junk in the upper bus nibble, which checks that only the low nibble is captured. Each of the three conditional jumps is run once with its own flag set and once with a different flag set. That separates a correct flag slice from a swapped or ignored one. The six ALU opcodes are each checked against a single enable, which exposes an off-by-one in the decoder mapping. HALT is run through to the wrap, which tells a natural roll-over apart from an explicit clear. A reset is also applied in the middle of an instruction.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
    localparam int STEP_W  = 4;
    localparam int OP_W    = 4;
    localparam int FLAG_W  = 3;
    localparam int LINES_W = 16;
    localparam int SEL_W   = 3;
    localparam int NUM_ALU = 6;
    localparam int ADDR_W  = STEP_W + OP_W + FLAG_W;
    localparam int WORD_W  = LINES_W + SEL_W;

    localparam int B_PC_OE   = 0;
    localparam int B_MAR_WE  = 1;
    localparam int B_RAM_OE  = 2;
    localparam int B_IR_WE   = 3;
    localparam int B_PC_INC  = 4;
    localparam int B_ACC_WE  = 5;
    localparam int B_ACC_OE  = 6;
    localparam int B_BREG_WE = 7;
    localparam int B_OUT_WE  = 8;
    localparam int B_RAM_WE  = 9;
    localparam int B_PC_WE   = 10;
    localparam int B_IR_CLR  = 11;
    localparam int B_STP_CLR = 12;
    localparam int B_HALT    = 13;

    localparam int F_LT = 0;
    localparam int F_EQ = 1;
    localparam int F_GT = 2;

    localparam logic [STEP_W-1:0] ST_FADDR = 4'd0;
    localparam logic [STEP_W-1:0] ST_FREAD = 4'd1;
    localparam logic [STEP_W-1:0] ST_FINC  = 4'd2;
    localparam logic [STEP_W-1:0] ST_X0    = 4'd3;
    localparam logic [STEP_W-1:0] ST_X1    = 4'd4;
    localparam logic [STEP_W-1:0] ST_X2    = 4'd5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP, OP_LDA, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT,
        OP_LDB, OP_OUT, OP_JMP, OP_JEQ, OP_JLT, OP_JGT, OP_STA, OP_HLT
    } op_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [LINES_W-1:0] lines;
    } uword_t;

    function automatic logic [LINES_W-1:0] bit_of(input int b);
        logic [LINES_W-1:0] v;
        v = '0;
        v[b] = 1'b1;
        return v;
    endfunction

    // Computes the microcode word for one address.
    function automatic uword_t ucode_word(input logic [ADDR_W-1:0] a);
        logic [STEP_W-1:0] st;
        op_e               op;
        logic [FLAG_W-1:0] fl;
        logic [LINES_W-1:0] fin, ld_mar;
        logic               taken;
        uword_t             w;
        st     = a[STEP_W-1:0];
        op     = op_e'(a[STEP_W+OP_W-1:STEP_W]);
        fl     = a[ADDR_W-1:STEP_W+OP_W];
        fin    = bit_of(B_IR_CLR) | bit_of(B_STP_CLR);
        ld_mar = bit_of(B_PC_OE) | bit_of(B_MAR_WE);
        taken  = 1'b0;
        w      = '0;
        if (st == ST_FADDR) begin
            w.lines = ld_mar;
        end else if (st == ST_FREAD) begin
            w.lines = bit_of(B_RAM_OE) | bit_of(B_IR_WE);
        end else if (st == ST_FINC) begin
            w.lines = bit_of(B_PC_INC);
        end else begin
            unique case (op)
                OP_NOP: if (st == ST_X0) w.lines = fin;
                OP_LDA, OP_LDB: begin
                    if (st == ST_X0) w.lines = ld_mar;
                    if (st == ST_X1) w.lines = bit_of(B_RAM_OE) |
                        bit_of((op == OP_LDA) ? B_ACC_WE : B_BREG_WE);
                    if (st == ST_X2) w.lines = bit_of(B_PC_INC) | fin;
                end
                OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                    if (st == ST_X0) begin
                        w.lines = bit_of(B_ACC_WE) | fin;
                        w.sel   = SEL_W'(op - 4'd1);
                    end
                end
                OP_OUT: if (st == ST_X0)
                    w.lines = bit_of(B_ACC_OE) | bit_of(B_OUT_WE) | fin;
                OP_JMP, OP_JEQ, OP_JLT, OP_JGT: begin
                    taken = (op == OP_JMP) || (op == OP_JEQ && fl[F_EQ]) ||
                            (op == OP_JLT && fl[F_LT]) || (op == OP_JGT && fl[F_GT]);
                    if (taken) begin
                        if (st == ST_X0) w.lines = ld_mar;
                        if (st == ST_X1) w.lines = bit_of(B_RAM_OE) | bit_of(B_PC_WE) | fin;
                    end else if (st == ST_X0) begin
                        w.lines = bit_of(B_PC_INC) | fin;
                    end
                end
                OP_STA: begin
                    if (st == ST_X0) w.lines = ld_mar;
                    if (st == ST_X1) w.lines = bit_of(B_RAM_OE) | bit_of(B_MAR_WE);
                    if (st == ST_X2) w.lines = bit_of(B_ACC_OE) | bit_of(B_RAM_WE) |
                                               bit_of(B_PC_INC) | fin;
                end
                OP_HLT: w.lines = bit_of(B_HALT);
            endcase
        end
        return w;
    endfunction
endpackage

// File: rtl/ucs_step_ctr.sv
module ucs_step_ctr
    import ucs_pkg::*;
#(
    parameter int W = STEP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] step
);
    logic [W-1:0] step_n;

    always_comb begin
        if (clr) step_n = '0;
        else     step_n = step + 1'b1;  // wraps from all-ones to zero
    end

    always_ff @(posedge clk) begin
        if (rst) step <= '0;
        else     step <= step_n;
    end
endmodule

// File: rtl/ucs_opreg.sv
module ucs_opreg
    import ucs_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
        else if (clr)  q <= '0;
    end
endmodule

// File: rtl/ucs_rom.sv
module ucs_rom
    import ucs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);
    always_comb word = ucode_word(addr);
endmodule

// File: rtl/ucs_alu_dec.sv
module ucs_alu_dec
    import ucs_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int NA = NUM_ALU
) (
    input  logic [SW-1:0] sel,
    output logic [NA-1:0] oe
);
    localparam int N = 1 << SW;
    logic [N-1:0] dec;
    logic         dec_unused;

    for (genvar k = 0; k < N; k++) begin : g_dec
        assign dec[k] = (sel == SW'(k));
    end
    // Code 0 means no function; codes above NA are left unmapped.
    for (genvar j = 0; j < NA; j++) begin : g_map
        assign oe[j] = dec[j + 1];
    end
    assign dec_unused = dec[0] | (|dec[N-1:NA+1]);
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import ucs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           bus_in,
    input  logic [FLAG_W-1:0]    cmp_flags,
    output logic [LINES_W-1:0]   ctrl_o,
    output logic [NUM_ALU-1:0]   alu_oe_o,
    output logic [STEP_W-1:0]    step_o,
    output logic [OP_W-1:0]      opcode_o
);
    logic [STEP_W-1:0] step;
    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] uaddr;
    uword_t            word;
    logic              bus_unused;

    assign bus_unused = ^bus_in[7:OP_W];
    assign uaddr      = {cmp_flags, opcode, step};

    ucs_step_ctr #(.W(STEP_W)) u_step (
        .clk(clk), .rst(rst), .clr(word.lines[B_STP_CLR]), .step(step)
    );

    ucs_opreg #(.W(OP_W)) u_op (
        .clk(clk), .rst(rst), .load(word.lines[B_IR_WE]),
        .clr(word.lines[B_IR_CLR]), .d(bus_in[OP_W-1:0]), .q(opcode)
    );

    ucs_rom u_rom (.addr(uaddr), .word(word));

    ucs_alu_dec #(.SW(SEL_W), .NA(NUM_ALU)) u_dec (
        .sel(word.sel), .oe(alu_oe_o)
    );

    assign ctrl_o   = word.lines;
    assign step_o   = step;
    assign opcode_o = opcode;
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker
    import ucs_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [7:0]           bus_in,
    input logic [LINES_W-1:0]   ctrl_o,
    input logic [NUM_ALU-1:0]   alu_oe_o,
    input logic [STEP_W-1:0]    step_o,
    input logic [OP_W-1:0]      opcode_o
);
    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (step_o == '0 && opcode_o == '0));

    p_end_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[B_STP_CLR] |=> (step_o == '0 && opcode_o == '0));

    p_end_pair_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[B_STP_CLR] |-> ctrl_o[B_IR_CLR]);

    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (step_o == ST_FADDR) |-> (ctrl_o == 16'h0003 && alu_oe_o == '0));

    p_ir_load_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[B_IR_WE] |=> (opcode_o == $past(bus_in[OP_W-1:0])));

    p_advance_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_o[B_STP_CLR] |=> (step_o == $past(step_o) + 4'd1));

    p_alu_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alu_oe_o));

    p_alu_step_r8: assert property (@(posedge clk) disable iff (rst)
        (alu_oe_o != '0) |-> (step_o == ST_X0));
endmodule

bind ucode_sequencer ucs_checker u_chk (
    .clk(clk), .rst(rst), .bus_in(bus_in), .ctrl_o(ctrl_o),
    .alu_oe_o(alu_oe_o), .step_o(step_o), .opcode_o(opcode_o)
);

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_in = 8'h00;
    logic [2:0]  cmp_flags = 3'b000;
    logic [15:0] ctrl_o;
    logic [5:0]  alu_oe_o;
    logic [3:0]  step_o;
    logic [3:0]  opcode_o;
    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ucode_sequencer u_ucode_sequencer (
        .clk(clk), .rst(rst), .bus_in(bus_in), .cmp_flags(cmp_flags),
        .ctrl_o(ctrl_o), .alu_oe_o(alu_oe_o), .step_o(step_o), .opcode_o(opcode_o)
    );

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic fetch(input logic [7:0] b, input string req);
        chk("R2", {req, " step0"}, ctrl_o, 16'h0003);
        chk("R8", {req, " no alu in fetch"}, 16'(alu_oe_o), 16'h0);
        tick;
        chk("R2", {req, " step1"}, ctrl_o, 16'h000C);
        bus_in = b;
        tick;
        bus_in = 8'h00;
        chk("R3", {req, " opcode low nibble"}, 16'(opcode_o), 16'(b[3:0]));
        chk("R2", {req, " step2"}, ctrl_o, 16'h0010);
        tick;
    endtask

    task automatic finish_check(input string req);
        tick;
        chk("R5", {req, " step cleared"}, 16'(step_o), 16'h0);
        chk("R5", {req, " opcode cleared"}, 16'(opcode_o), 16'h0);
    endtask

    task automatic t_reset;
        chk("R1", "step", 16'(step_o), 16'h0);
        chk("R1", "opcode", 16'(opcode_o), 16'h0);
        chk("R1", "ctrl", ctrl_o, 16'h0003);
        chk("R1", "alu", 16'(alu_oe_o), 16'h0);
    endtask

    task automatic t_nop;
        fetch(8'hA0, "nop");
        chk("R11", "nop step3", ctrl_o, 16'h1800);
        finish_check("nop");
    endtask

    task automatic t_load(input logic [7:0] b, input logic [15:0] mid, input string req);
        fetch(b, req);
        chk("R9", {req, " step3"}, ctrl_o, 16'h0003);
        tick;
        chk("R9", {req, " step4"}, ctrl_o, mid);
        tick;
        chk("R9", {req, " step5"}, ctrl_o, 16'h1810);
        finish_check(req);
    endtask

    task automatic t_alu;
        for (int op = 2; op <= 7; op++) begin
            fetch(8'(8'h50 | op), "alu");
            chk("R7", "alu ctrl", ctrl_o, 16'h1820);
            chk("R7", "alu enable", 16'(alu_oe_o), 16'(1 << (op - 2)));
            finish_check("alu");
        end
    endtask

    task automatic t_out;
        fetch(8'h39, "out");
        chk("R11", "out step3", ctrl_o, 16'h1940);
        chk("R8", "out no alu", 16'(alu_oe_o), 16'h0);
        finish_check("out");
    endtask

    task automatic t_jump(input logic [3:0] op, input logic [2:0] fl,
                          input logic tk, input string req);
        cmp_flags = fl;
        fetch({4'hC, op}, req);
        if (tk) begin
            chk("R10", {req, " taken step3"}, ctrl_o, 16'h0003);
            tick;
            chk("R10", {req, " taken step4"}, ctrl_o, 16'h1C04);
        end else begin
            chk("R10", {req, " not taken step3"}, ctrl_o, 16'h1810);
        end
        finish_check(req);
        cmp_flags = 3'b000;
    endtask

    task automatic t_flags_addr;
        // R4: same opcode and step, two flag values, two words
        cmp_flags = 3'b010;
        fetch(8'h0B, "addr");
        chk("R4", "jeq eq=1", ctrl_o, 16'h0003);
        cmp_flags = 3'b001;
        #1;
        chk("R4", "jeq eq=0", ctrl_o, 16'h1810);
        finish_check("addr");
        cmp_flags = 3'b000;
    endtask

    task automatic t_sta;
        fetch(8'h2E, "sta");
        chk("R11", "sta step3", ctrl_o, 16'h0003);
        tick;
        chk("R11", "sta step4", ctrl_o, 16'h0006);
        tick;
        chk("R11", "sta step5", ctrl_o, 16'h1A50);
        finish_check("sta");
    endtask

    task automatic t_halt_wrap;
        fetch(8'hFF, "halt");
        for (int s = 3; s <= 15; s++) begin
            chk("R12", "halt step", 16'(step_o), 16'(s));
            chk("R12", "halt ctrl", ctrl_o, 16'h2000);
            tick;
        end
        chk("R6", "wrap step", 16'(step_o), 16'h0);
        chk("R6", "wrap keeps opcode", 16'(opcode_o), 16'hF);
        chk("R6", "wrap ctrl", ctrl_o, 16'h0003);
        fetch(8'h00, "after wrap");
        finish_check("after wrap");
    endtask

    task automatic t_mid_reset;
        fetch(8'h01, "midrst");
        tick;
        chk("R12", "midrst at step4", 16'(step_o), 16'h4);
        rst = 1'b1;
        tick;
        rst = 1'b0;
        chk("R12", "midrst step", 16'(step_o), 16'h0);
        chk("R12", "midrst opcode", 16'(opcode_o), 16'h0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tick;
        tick;
        t_reset;
        rst = 1'b0;
        t_nop;
        t_load(8'hF1, 16'h0024, "lda");
        t_load(8'h78, 16'h0084, "ldb");
        t_alu;
        t_out;
        t_jump(4'hA, 3'b000, 1'b1, "jmp");
        t_jump(4'hB, 3'b010, 1'b1, "jeq hit");
        t_jump(4'hB, 3'b101, 1'b0, "jeq miss");
        t_jump(4'hC, 3'b001, 1'b1, "jlt hit");
        t_jump(4'hC, 3'b100, 1'b0, "jlt miss");
        t_jump(4'hD, 3'b100, 1'b1, "jgt hit");
        t_jump(4'hD, 3'b011, 1'b0, "jgt miss");
        t_flags_addr;
        t_sta;
        t_halt_wrap;
        t_mid_reset;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule